// File: doc/BRIEF.md
# In-Order Retirement Buffer with Branch Recovery

This block keeps a circular record of every instruction that has been renamed and sent out for execution. Records are kept in program order. Execution units report completion back by slot tag, in any order, and the buffer retires records only from its oldest end, up to two per cycle. Retirement of an instruction that writes a register updates a committed rename table. Each entry of that table holds the physical register that now backs an architectural register; it holds a pointer, not the data value.

Branches are assumed to have been fetched as taken. When a retiring branch reports that its not-equal test was false, the guess was wrong. The buffer then discards every younger record and raises a one-cycle flush carrying the restart address, which is the branch address plus one. A retiring halt instruction freezes the machine until reset. Decode allocates through a simple valid/tag port and must hold off while the buffer reports full.

Top module: `inorder_commit_rob`

## Requirements
- R1: After reset the buffer is empty, `alloc_tag` is 0, `full`, `flush`, `halted` and `retire_cnt` are 0, and committed map entry i holds physical pointer i.
- R2: A record is accepted when `alloc_valid` is high and `full`, `halted` and `flush` are all low. It is written at slot `alloc_tag`, and the tag then advances by one. In any other case the request has no effect.
- R3: A completion on any port marks the tagged record complete and stores its not-equal flag. Both ports may complete different records in the same cycle. A halt record (kind 2'b10) counts as complete when allocated.
- R4: Records retire strictly in program order, starting at the oldest. A record retires only when it is complete, and at most two retire per cycle. An incomplete oldest record blocks all retirement. `retire_cnt` shows the number retired at the previous edge.
- R5: A retiring ALU record (kind 2'b00) with `alloc_has_dst` set writes its physical pointer into map entry `alloc_areg`. Branch and halt records leave the map unchanged.
- R6: A branch record (kind 2'b01) that retires with its not-equal flag 0 makes `flush` high for exactly the next cycle, with `flush_pc` equal to its address plus one. All younger records are discarded without touching the map, and the next tag becomes the slot that follows the branch.
- R7: A branch that retires with its not-equal flag 1 causes no flush, and records behind it may retire in the same cycle.
- R8: `full` is high when all DEPTH slots hold records. Tags wrap from DEPTH-1 back to 0.
- R9: A retiring halt sets `halted`, which stays high until reset. Records after the halt never retire, and allocation is refused while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode presents a record |
| alloc_kind | input | 2 | 00 ALU, 01 branch, 10 halt |
| alloc_has_dst | input | 1 | ALU record writes a register |
| alloc_areg | input | $clog2(NAREG) | Architectural destination |
| alloc_preg | input | PREG_W | Physical destination pointer |
| alloc_pc | input | PC_W | Instruction address |
| alloc_tag | output | $clog2(DEPTH) | Slot the next accepted record takes |
| full | output | 1 | All slots occupied |
| cmp_valid | input | NCMP | Completion strobe per port |
| cmp_tag | input | NCMP*$clog2(DEPTH) | Completed slot per port |
| cmp_ne | input | NCMP | Branch not-equal outcome per port |
| retire_cnt | output | $clog2(RET_W+1) | Records retired at the last edge |
| arch_map | output | NAREG*PREG_W | Committed map, entry i at bits i*PREG_W |
| flush | output | 1 | One-cycle mispredict recovery pulse |
| flush_pc | output | PC_W | Restart address |
| halted | output | 1 | Sticky halt state |

## Verification
The bench builds the block with DEPTH set to 8 and keeps two completion ports and a retirement width of two. With only eight slots, filling the buffer, pushing a refused request against it and wrapping the tags all the way back to the start take a few dozen cycles. With two ports and two retire lanes, the bench can complete and retire two records in one cycle. It can also place a mispredicted branch or a halt in either retire lane, and check that the lane behind it is blocked or committed as required.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU  = 2'b00,
    K_BR   = 2'b01,
    K_HALT = 2'b10
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int RC_W  = $clog2(RET_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_we,
  input  logic [RC_W-1:0]  n_ret,
  input  logic             recover,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  // DEPTH must be a power of two so pointer arithmetic wraps naturally.
  logic [PTR_W-1:0] head_nx;

  assign head_nx = head + PTR_W'(n_ret);
  assign full    = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head_nx;
      if (recover) begin
        tail  <= head_nx;
        count <= '0;
      end else begin
        tail  <= tail + PTR_W'(alloc_we);
        count <= count + CNT_W'(alloc_we) - CNT_W'(n_ret);
      end
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R8
  ptr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tail - head) == count[PTR_W-1:0]);
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RET_W  = 2,
  parameter int NCMP   = 2,
  parameter int AREG_W = 2,
  parameter int PREG_W = 5,
  parameter int PC_W   = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PAY_W = 2 + 1 + AREG_W + PREG_W + PC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_we,
  input  logic [PTR_W-1:0]        tail,
  input  logic [1:0]              a_kind,
  input  logic                    a_dst,
  input  logic [AREG_W-1:0]       a_areg,
  input  logic [PREG_W-1:0]       a_preg,
  input  logic [PC_W-1:0]         a_pc,
  input  logic [NCMP-1:0]         cmp_valid,
  input  logic [NCMP*PTR_W-1:0]   cmp_tag,
  input  logic [NCMP-1:0]         cmp_ne,
  input  logic [PTR_W-1:0]        head,
  input  logic [RET_W-1:0]        fire,
  input  logic                    recover,
  output logic [RET_W-1:0]        s_valid,
  output logic [RET_W-1:0]        s_done,
  output logic [RET_W-1:0]        s_ne,
  output logic [RET_W*2-1:0]      s_kind,
  output logic [RET_W-1:0]        s_dst,
  output logic [RET_W*AREG_W-1:0] s_areg,
  output logic [RET_W*PREG_W-1:0] s_preg,
  output logic [RET_W*PC_W-1:0]   s_pc
);
  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] ne_q;
  logic [PTR_W-1:0] slot_idx [RET_W];

  // Payload: written once at allocation, never reset, read at the head window.
  always_ff @(posedge clk) begin
    if (alloc_we) pay_mem[tail] <= {a_kind, a_dst, a_areg, a_preg, a_pc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      done_q  <= '0;
      ne_q    <= '0;
    end else begin
      for (int c = 0; c < NCMP; c++) begin
        if (cmp_valid[c] && valid_q[cmp_tag[c*PTR_W +: PTR_W]]) begin
          done_q[cmp_tag[c*PTR_W +: PTR_W]] <= 1'b1;
          ne_q[cmp_tag[c*PTR_W +: PTR_W]]   <= cmp_ne[c];
        end
      end
      for (int k = 0; k < RET_W; k++) begin
        if (fire[k]) valid_q[slot_idx[k]] <= 1'b0;
      end
      if (alloc_we) begin
        valid_q[tail] <= 1'b1;
        done_q[tail]  <= (a_kind == K_HALT);
        ne_q[tail]    <= 1'b0;
      end
      if (recover) valid_q <= '0;
    end
  end

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic [PAY_W-1:0] rd;
    assign slot_idx[k] = head + PTR_W'(k);
    assign rd          = pay_mem[slot_idx[k]];
    assign s_valid[k]  = valid_q[slot_idx[k]];
    assign s_done[k]   = done_q[slot_idx[k]];
    assign s_ne[k]     = ne_q[slot_idx[k]];
    assign {s_kind[k*2 +: 2], s_dst[k], s_areg[k*AREG_W +: AREG_W],
            s_preg[k*PREG_W +: PREG_W], s_pc[k*PC_W +: PC_W]} = rd;

    // R4
    retire_done_chk: assert property (@(posedge clk) disable iff (rst)
      fire[k] |-> (valid_q[slot_idx[k]] && done_q[slot_idx[k]]));
  end

  // R2
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_we |-> !valid_q[tail]);
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
#(
  parameter int RET_W = 2,
  parameter int PC_W  = 8,
  localparam int RC_W = $clog2(RET_W + 1)
) (
  input  logic                  halted,
  input  logic [RET_W-1:0]      s_valid,
  input  logic [RET_W-1:0]      s_done,
  input  logic [RET_W-1:0]      s_ne,
  input  logic [RET_W*2-1:0]    s_kind,
  input  logic [RET_W*PC_W-1:0] s_pc,
  output logic [RET_W-1:0]      fire,
  output logic [RC_W-1:0]       n_ret,
  output logic                  mis,
  output logic [PC_W-1:0]       mis_pc,
  output logic                  halt_hit
);
  logic go;

  always_comb begin
    go       = !halted;
    fire     = '0;
    n_ret    = '0;
    mis      = 1'b0;
    mis_pc   = '0;
    halt_hit = 1'b0;
    for (int k = 0; k < RET_W; k++) begin
      if (go && s_valid[k] && s_done[k]) begin
        fire[k] = 1'b1;
        n_ret   = n_ret + RC_W'(1);
        if (s_kind[k*2 +: 2] == K_BR && !s_ne[k]) begin
          mis    = 1'b1;
          mis_pc = s_pc[k*PC_W +: PC_W] + PC_W'(1);
          go     = 1'b0;
        end else if (s_kind[k*2 +: 2] == K_HALT) begin
          halt_hit = 1'b1;
          go       = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_arch_map.sv
module rob_arch_map #(
  parameter int NAREG  = 4,
  parameter int PREG_W = 5,
  parameter int RET_W  = 2,
  localparam int AREG_W = $clog2(NAREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [RET_W-1:0]        wr_en,
  input  logic [RET_W*AREG_W-1:0] wr_areg,
  input  logic [RET_W*PREG_W-1:0] wr_preg,
  output logic [NAREG*PREG_W-1:0] map_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NAREG; i++) map_q[i*PREG_W +: PREG_W] <= PREG_W'(i);
    end else begin
      // Lane order matches program order: a younger lane overrides an older one.
      for (int k = 0; k < RET_W; k++) begin
        if (wr_en[k])
          map_q[wr_areg[k*AREG_W +: AREG_W]*PREG_W +: PREG_W] <= wr_preg[k*PREG_W +: PREG_W];
      end
    end
  end

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(map_q));
endmodule

// File: rtl/inorder_commit_rob.sv
module inorder_commit_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RET_W  = 2,
  parameter int NCMP   = 2,
  parameter int NAREG  = 4,
  parameter int PREG_W = 5,
  parameter int PC_W   = 8,
  localparam int AREG_W = $clog2(NAREG),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int RC_W   = $clog2(RET_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_valid,
  input  logic [1:0]              alloc_kind,
  input  logic                    alloc_has_dst,
  input  logic [AREG_W-1:0]       alloc_areg,
  input  logic [PREG_W-1:0]       alloc_preg,
  input  logic [PC_W-1:0]         alloc_pc,
  output logic [PTR_W-1:0]        alloc_tag,
  output logic                    full,
  input  logic [NCMP-1:0]         cmp_valid,
  input  logic [NCMP*PTR_W-1:0]   cmp_tag,
  input  logic [NCMP-1:0]         cmp_ne,
  output logic [RC_W-1:0]         retire_cnt,
  output logic [NAREG*PREG_W-1:0] arch_map,
  output logic                    flush,
  output logic [PC_W-1:0]         flush_pc,
  output logic                    halted
);
  logic                    alloc_we;
  logic [PTR_W-1:0]        head, tail;
  logic [CNT_W-1:0]        count;
  logic [RET_W-1:0]        s_valid, s_done, s_ne, s_dst, fire, wr_en;
  logic [RET_W*2-1:0]      s_kind;
  logic [RET_W*AREG_W-1:0] s_areg;
  logic [RET_W*PREG_W-1:0] s_preg;
  logic [RET_W*PC_W-1:0]   s_pc;
  logic [RC_W-1:0]         n_ret;
  logic                    mis, halt_hit;
  logic [PC_W-1:0]         mis_pc;

  assign alloc_we  = alloc_valid && !full && !halted && !flush;
  assign alloc_tag = tail;

  rob_ptrs #(.DEPTH(DEPTH), .RET_W(RET_W)) ptrs_i (
    .clk(clk), .rst(rst), .alloc_we(alloc_we), .n_ret(n_ret), .recover(mis),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_store #(
    .DEPTH(DEPTH), .RET_W(RET_W), .NCMP(NCMP), .AREG_W(AREG_W),
    .PREG_W(PREG_W), .PC_W(PC_W)
  ) store_i (
    .clk(clk), .rst(rst), .alloc_we(alloc_we), .tail(tail),
    .a_kind(alloc_kind), .a_dst(alloc_has_dst), .a_areg(alloc_areg),
    .a_preg(alloc_preg), .a_pc(alloc_pc),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_ne(cmp_ne),
    .head(head), .fire(fire), .recover(mis),
    .s_valid(s_valid), .s_done(s_done), .s_ne(s_ne), .s_kind(s_kind),
    .s_dst(s_dst), .s_areg(s_areg), .s_preg(s_preg), .s_pc(s_pc)
  );

  rob_retire_sel #(.RET_W(RET_W), .PC_W(PC_W)) sel_i (
    .halted(halted), .s_valid(s_valid), .s_done(s_done), .s_ne(s_ne),
    .s_kind(s_kind), .s_pc(s_pc), .fire(fire), .n_ret(n_ret),
    .mis(mis), .mis_pc(mis_pc), .halt_hit(halt_hit)
  );

  for (genvar k = 0; k < RET_W; k++) begin : g_wr
    assign wr_en[k] = fire[k] && s_dst[k] && (s_kind[k*2 +: 2] == K_ALU);
  end

  rob_arch_map #(.NAREG(NAREG), .PREG_W(PREG_W), .RET_W(RET_W)) map_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_areg(s_areg), .wr_preg(s_preg),
    .map_q(arch_map)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush      <= 1'b0;
      flush_pc   <= '0;
      halted     <= 1'b0;
      retire_cnt <= '0;
    end else begin
      flush      <= mis;
      if (mis) flush_pc <= mis_pc;
      halted     <= halted | halt_hit;
      retire_cnt <= n_ret;
    end
  end

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    mis |=> (flush && count == '0));

  // R6
  flush_single_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(arch_map));

  // R4
  retire_order_chk: assert property (@(posedge clk) disable iff (rst)
    fire[1] |-> fire[0]);
endmodule

// File: tb/inorder_commit_rob_tb_top.sv
module inorder_commit_rob_tb_top;
  localparam int DEPTH = 8, RET_W = 2, NCMP = 2, NAREG = 4, PREG_W = 5, PC_W = 8;
  localparam int AREG_W = 2, PTR_W = 3, RC_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0;
  logic [1:0] alloc_kind = '0;
  logic alloc_has_dst = 1'b0;
  logic [AREG_W-1:0] alloc_areg = '0;
  logic [PREG_W-1:0] alloc_preg = '0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic [PTR_W-1:0] alloc_tag;
  logic full;
  logic [NCMP-1:0] cmp_valid = '0;
  logic [NCMP*PTR_W-1:0] cmp_tag = '0;
  logic [NCMP-1:0] cmp_ne = '0;
  logic [RC_W-1:0] retire_cnt;
  logic [NAREG*PREG_W-1:0] arch_map;
  logic flush;
  logic [PC_W-1:0] flush_pc;
  logic halted;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_map [NAREG];

  always #5 clk = ~clk;

  inorder_commit_rob #(
    .DEPTH(DEPTH), .RET_W(RET_W), .NCMP(NCMP), .NAREG(NAREG),
    .PREG_W(PREG_W), .PC_W(PC_W)
  ) dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_has_dst(alloc_has_dst), .alloc_areg(alloc_areg),
    .alloc_preg(alloc_preg), .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .full(full), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_ne(cmp_ne),
    .retire_cnt(retire_cnt), .arch_map(arch_map), .flush(flush),
    .flush_pc(flush_pc), .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mapv(input int i);
    return int'(arch_map[i*PREG_W +: PREG_W]);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic d, input int a,
                          input int p, input int pc, output int tag);
    alloc_valid   = 1'b1;
    alloc_kind    = k;
    alloc_has_dst = d;
    alloc_areg    = AREG_W'(a);
    alloc_preg    = PREG_W'(p);
    alloc_pc      = PC_W'(pc);
    tag           = int'(alloc_tag);
    step();
    alloc_valid   = 1'b0;
  endtask

  task automatic do_cmp(input logic v0, input int t0, input logic ne0,
                        input logic v1, input int t1, input logic ne1);
    cmp_valid = {v1, v0};
    cmp_tag   = {PTR_W'(t1), PTR_W'(t0)};
    cmp_ne    = {ne1, ne0};
    step();
    cmp_valid = '0;
  endtask

  task automatic check_map(input string req);
    for (int i = 0; i < NAREG; i++) chk(req, mapv(i), exp_map[i]);
  endtask

  task automatic t_reset();
    chk("R1 tag", int'(alloc_tag), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 flush", int'(flush), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 retire_cnt", int'(retire_cnt), 0);
    for (int i = 0; i < NAREG; i++) exp_map[i] = i;
    check_map("R1 map");
  endtask

  task automatic t_order();
    int ta, tb, tc;
    do_alloc(2'b00, 1'b1, 1, 10, 8'h01, ta);
    do_alloc(2'b00, 1'b1, 1, 11, 8'h02, tb);
    do_alloc(2'b00, 1'b1, 2, 12, 8'h03, tc);
    chk("R2 tag advance", int'(alloc_tag), 3);
    do_cmp(1'b1, tc, 1'b0, 1'b1, tb, 1'b0);
    step();
    chk("R4 blocked by incomplete head", int'(retire_cnt), 0);
    check_map("R4 map untouched");
    do_cmp(1'b1, ta, 1'b0, 1'b0, 0, 1'b0);
    chk("R3 done seen next edge", int'(retire_cnt), 0);
    step();
    chk("R4 two retire", int'(retire_cnt), 2);
    exp_map[1] = 11;
    check_map("R5 younger lane wins");
    step();
    chk("R4 third retires", int'(retire_cnt), 1);
    exp_map[2] = 12;
    check_map("R5 write");
  endtask

  task automatic t_good_branch();
    int tb, tx;
    do_alloc(2'b01, 1'b0, 0, 0, 8'h10, tb);
    do_alloc(2'b00, 1'b1, 0, 13, 8'h11, tx);
    do_cmp(1'b1, tb, 1'b1, 1'b1, tx, 1'b0);
    step();
    chk("R7 no flush", int'(flush), 0);
    chk("R7 both retire", int'(retire_cnt), 2);
    exp_map[0] = 13;
    check_map("R7 map");
  endtask

  task automatic t_mispredict_lane1();
    int tx, tb, ty, tbefore;
    do_alloc(2'b00, 1'b1, 0, 20, 8'h2F, tx);
    do_alloc(2'b01, 1'b0, 0, 0, 8'h30, tb);
    do_alloc(2'b00, 1'b1, 3, 21, 8'h31, ty);
    do_cmp(1'b1, ty, 1'b0, 1'b0, 0, 1'b0);
    do_cmp(1'b1, tx, 1'b0, 1'b1, tb, 1'b0);
    step();
    chk("R6 flush high", int'(flush), 1);
    chk("R6 flush_pc", int'(flush_pc), 8'h31);
    chk("R6 retire count", int'(retire_cnt), 2);
    chk("R6 tag reset", int'(alloc_tag), ty);
    exp_map[0] = 20;
    check_map("R6 younger discarded");
    tbefore = int'(alloc_tag);
    alloc_valid = 1'b1; alloc_kind = 2'b00; alloc_has_dst = 1'b1;
    alloc_areg = 2'd3; alloc_preg = 5'd25;
    step();
    alloc_valid = 1'b0;
    chk("R2 refused during flush", int'(alloc_tag), tbefore);
    chk("R6 single pulse", int'(flush), 0);
    step();
    step();
    chk("R6 nothing retires", int'(retire_cnt), 0);
    check_map("R6 map after flush");
  endtask

  task automatic t_mispredict_lane0();
    int tb, tz;
    do_alloc(2'b01, 1'b0, 0, 0, 8'h40, tb);
    do_alloc(2'b00, 1'b1, 2, 22, 8'h41, tz);
    do_cmp(1'b1, tb, 1'b0, 1'b1, tz, 1'b0);
    step();
    chk("R6 flush lane0", int'(flush), 1);
    chk("R6 flush_pc lane0", int'(flush_pc), 8'h41);
    chk("R6 lane1 blocked", int'(retire_cnt), 1);
    chk("R6 tag to slot after branch", int'(alloc_tag), tz);
    check_map("R6 map lane0");
    step();
  endtask

  task automatic t_full_wrap();
    int t[DEPTH];
    int tbefore;
    for (int i = 0; i < DEPTH; i++) do_alloc(2'b00, 1'b1, 1, 16 + i, i, t[i]);
    chk("R8 full", int'(full), 1);
    tbefore = int'(alloc_tag);
    chk("R8 wrap tag", tbefore, t[0]);
    alloc_valid = 1'b1; alloc_kind = 2'b00; alloc_has_dst = 1'b1;
    alloc_areg = 2'd2; alloc_preg = 5'd30;
    step();
    alloc_valid = 1'b0;
    chk("R2 refused when full", int'(alloc_tag), tbefore);
    for (int i = 0; i < DEPTH; i += 2) do_cmp(1'b1, t[i], 1'b0, 1'b1, t[i+1], 1'b0);
    for (int i = 0; i < 4; i++) step();
    chk("R8 drained", int'(full), 0);
    exp_map[1] = 16 + DEPTH - 1;
    check_map("R2 R8 map after drain");
    chk("R8 tag after wrap", int'(alloc_tag), t[0]);
  endtask

  task automatic t_halt();
    int ta, th, tc, tbefore;
    do_alloc(2'b00, 1'b1, 1, 7, 8'h50, ta);
    do_alloc(2'b10, 1'b0, 0, 0, 8'h51, th);
    do_alloc(2'b00, 1'b1, 2, 8, 8'h52, tc);
    do_cmp(1'b1, ta, 1'b0, 1'b1, tc, 1'b0);
    step();
    chk("R9 halted", int'(halted), 1);
    chk("R3 halt complete at alloc", int'(retire_cnt), 2);
    exp_map[1] = 7;
    check_map("R9 map at halt");
    step();
    step();
    chk("R9 no more retire", int'(retire_cnt), 0);
    check_map("R9 map frozen");
    tbefore = int'(alloc_tag);
    alloc_valid = 1'b1; alloc_kind = 2'b00;
    step();
    alloc_valid = 1'b0;
    chk("R9 alloc refused", int'(alloc_tag), tbefore);
    chk("R9 sticky", int'(halted), 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    t_reset();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_order();
    t_good_branch();
    t_mispredict_lane1();
    t_mispredict_lane0();
    t_full_wrap();
    t_halt();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule